// File: doc/BRIEF.md
# Trigger Source Selector and Hold-Time Qualifier

This block sits between the word comparators of a multi-channel capture engine and the trigger latch that ends acquisition. It picks the raw trigger from one of two places: the logical AND of two half-width word-match flags (so two 16-channel comparators act as one 32-channel comparator), or an external trigger pin whose sense can be flipped. In both cases the result is an active-high raw trigger.

The raw trigger then passes through a hold-time qualifier clocked by the sample clock. A 2-bit code chooses how many sample edges the raw trigger must stay high before it is passed on: none, 2, 4 or 8. A count runs only while the raw trigger is high and is cleared as soon as it falls. Any pulse shorter than the selected window is therefore dropped, which rejects narrow glitches. Once the window is met, the count stops at the target. The qualified output then stays high for as long as the raw trigger does.

Top module: `trig_qualifier`

## Requirements
- R1: With the internal source selected (src_ext_i = 0), the raw trigger is match_lo_i AND match_hi_i; with dly_code_i = 0 the output equals it in the same cycle.
- R2: With the external source selected (src_ext_i = 1), the raw trigger is ext_trig_i XOR ext_inv_i; ext_inv_i = 1 makes a low pin level the active one.
- R3: While the internal source is selected, ext_inv_i has no effect on the output.
- R4: dly_code_i = 0 passes the raw trigger to qual_trig_o combinationally, with no sample-edge latency.
- R5: dly_code_i values 1, 2 and 3 require 2, 4 and 8 rising sample edges, respectively, at which the raw trigger is high. qual_trig_o rises right after the last of these edges and not earlier.
- R6: A raw trigger low at a sample edge clears the count. A pulse shorter than the window never raises qual_trig_o, and a later pulse starts counting from zero.
- R7: After the window is met, the count saturates. qual_trig_o stays high without a gap for as long as the raw trigger stays high, even past 16 edges.
- R8: qual_trig_o is never high while the raw trigger is low, and it falls in the same cycle as the raw trigger.
- R9: While rst_n is low, the count is held at zero, so for a nonzero code qual_trig_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| match_lo_i | input | 1 | Match flag from the lower-half word comparator |
| match_hi_i | input | 1 | Match flag from the upper-half word comparator |
| ext_trig_i | input | 1 | External trigger pin level |
| src_ext_i | input | 1 | 1 selects the external pin, 0 the internal match |
| ext_inv_i | input | 1 | 1 inverts the external pin (ignored for internal source) |
| dly_code_i | input | 2 | Hold window: 0 none, 1 two, 2 four, 3 eight edges |
| qual_trig_o | output | 1 | Qualified active-high trigger |

## Verification
The selector is driven with all four combinations of the two match flags, and with both pin levels under both inversion settings. This separates a true AND from an OR or a single-flag pass, and shows whether the polarity bit is applied, ignored or forced. For each nonzero code, the raw trigger is held high and the output is sampled after every edge. This pins the exact window length and catches off-by-one and code-to-length mapping errors. Pulses one edge short of the window, followed by a fresh full-length pulse, separate a count that clears on a low level from one that merely pauses. A hold of twenty edges exposes any count that wraps instead of saturating.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;

    localparam int CODE_W = 2;
    localparam int CNT_W  = 4;

    typedef logic [CODE_W-1:0] dly_code_t;
    typedef logic [CNT_W-1:0]  hold_cnt_t;

    typedef struct packed {
        hold_cnt_t cnt;
    } hold_state_t;

    // Code 0 means no window; code k (k>0) means 2**k edges.
    function automatic hold_cnt_t code_to_target(input dly_code_t code);
        hold_cnt_t one;
        one = '0;
        one[0] = 1'b1;
        if (code == '0) return '0;
        return hold_cnt_t'(one << code);
    endfunction

endpackage

// File: rtl/trig_src_sel.sv
module trig_src_sel (
    input  logic match_lo_i,
    input  logic match_hi_i,
    input  logic ext_trig_i,
    input  logic src_ext_i,
    input  logic ext_inv_i,
    output logic raw_trig_o
);

    logic int_match;
    logic eff_inv;
    logic picked;

    always_comb begin
        int_match  = match_lo_i & match_hi_i;
        // Inversion only applies to the external pin.
        eff_inv    = src_ext_i & ext_inv_i;
        picked     = src_ext_i ? ext_trig_i : int_match;
        raw_trig_o = picked ^ eff_inv;
    end

endmodule

// File: rtl/trig_hold_filter.sv
module trig_hold_filter
    import trig_qual_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig_i,
    input  dly_code_t code_i,
    output logic      qual_o
);

    hold_state_t st_d, st_q;
    hold_cnt_t   tgt;
    logic        reached;

    always_comb begin
        tgt     = code_to_target(code_i);
        reached = (st_q.cnt >= tgt);
        st_d    = st_q;
        if (!trig_i) begin
            st_d.cnt = '0;
        end else if (!reached) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (code_i == '0) begin
            qual_o = trig_i;
        end else begin
            qual_o = trig_i & reached;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a low trigger at an edge leaves the count at zero
    p_clear_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> (st_q.cnt == '0));

    // R5: below target with trigger high, count advances by one
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && st_q.cnt < tgt) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R7: at or past target with trigger high, count holds (no wrap)
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && st_q.cnt >= tgt) |=> $stable(st_q.cnt));

endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
    import trig_qual_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_lo_i,
    input  logic              match_hi_i,
    input  logic              ext_trig_i,
    input  logic              src_ext_i,
    input  logic              ext_inv_i,
    input  logic [CODE_W-1:0] dly_code_i,
    output logic              qual_trig_o
);

    logic raw_trig;

    trig_src_sel u_sel (
        .match_lo_i (match_lo_i),
        .match_hi_i (match_hi_i),
        .ext_trig_i (ext_trig_i),
        .src_ext_i  (src_ext_i),
        .ext_inv_i  (ext_inv_i),
        .raw_trig_o (raw_trig)
    );

    trig_hold_filter u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (raw_trig),
        .code_i (dly_code_i),
        .qual_o (qual_trig_o)
    );

    // R8: output never asserted without the selected raw trigger
    p_out_needs_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        qual_trig_o |-> raw_trig);

    // R3: internal source with no window follows the two match flags only
    p_int_ignores_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ext_i && dly_code_i == '0) |-> (qual_trig_o == (match_lo_i & match_hi_i)));

    // R2: external source with no window follows pin xor inversion
    p_ext_polarity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext_i && dly_code_i == '0) |-> (qual_trig_o == (ext_trig_i ^ ext_inv_i)));

endmodule

// File: tb/sim_trig_qualifier.sv
module sim_trig_qualifier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mlo = 1'b0, mhi = 1'b0, ext = 1'b0, sel = 1'b0, inv = 1'b0;
    logic [1:0] code = 2'd0;
    logic       qual;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    trig_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .match_lo_i(mlo), .match_hi_i(mhi),
        .ext_trig_i(ext), .src_ext_i(sel), .ext_inv_i(inv),
        .dly_code_i(code), .qual_trig_o(qual)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // advance to next negedge, inputs are changed there, sample 1 ns later
    task automatic to_neg();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sel = 1'b1; inv = 1'b0; ext = 1'b1; code = 2'd1;
        repeat (4) to_neg();
        settle();
        chk("R9 reset holds output low", qual, 1'b0);
        to_neg(); ext = 1'b0; rst_n = 1'b1; settle();
        chk("R9 after reset", qual, 1'b0);
    endtask

    task automatic t_internal();
        sel = 1'b0; inv = 1'b0; code = 2'd0;
        for (int k = 0; k < 4; k++) begin
            to_neg(); {mlo, mhi} = 2'(k); settle();
            chk("R1 internal AND", qual, (k == 3));
        end
        to_neg(); mlo = 1'b0; mhi = 1'b0; settle();
    endtask

    task automatic t_ext();
        sel = 1'b1; code = 2'd0;
        for (int k = 0; k < 4; k++) begin
            to_neg(); inv = k[1]; ext = k[0]; settle();
            chk("R2 external polarity", qual, k[1] ^ k[0]);
        end
        to_neg(); inv = 1'b0; ext = 1'b0; settle();
    endtask

    task automatic t_inv_ignored();
        sel = 1'b0; code = 2'd0; inv = 1'b1;
        to_neg(); mlo = 1'b0; mhi = 1'b0; settle();
        chk("R3 inv ignored, no match", qual, 1'b0);
        to_neg(); mlo = 1'b1; mhi = 1'b1; settle();
        chk("R3 inv ignored, match", qual, 1'b1);
        to_neg(); mlo = 1'b0; mhi = 1'b0; inv = 1'b0; settle();
    endtask

    task automatic t_zero_delay();
        sel = 1'b1; inv = 1'b0; code = 2'd0;
        to_neg(); ext = 1'b1; #0.5;
        chk("R4 immediate pass", qual, 1'b1);
        to_neg(); ext = 1'b0; #0.5;
        chk("R4 immediate drop", qual, 1'b0);
    endtask

    task automatic t_window(input logic [1:0] c, input int n);
        sel = 1'b1; inv = 1'b0;
        to_neg(); code = c; ext = 1'b0;
        to_neg(); ext = 1'b1; settle();
        chk("R5 low before first edge", qual, 1'b0);
        for (int e = 1; e <= n; e++) begin
            to_neg(); settle();
            chk((e == n) ? "R5 rises after window" : "R5 low inside window", qual, (e >= n));
        end
        to_neg(); ext = 1'b0; settle();
        chk("R8 falls with raw", qual, 1'b0);
    endtask

    task automatic t_short(input logic [1:0] c, input int n);
        sel = 1'b1; inv = 1'b0;
        to_neg(); code = c; ext = 1'b0;
        to_neg(); ext = 1'b1;
        for (int e = 1; e < n; e++) begin
            to_neg(); settle();
            chk("R6 short pulse stays low", qual, 1'b0);
        end
        ext = 1'b0;
        to_neg(); ext = 1'b1;
        for (int e = 1; e <= n; e++) begin
            to_neg(); settle();
            chk("R6 restart from zero", qual, (e >= n));
        end
        to_neg(); ext = 1'b0; settle();
    endtask

    task automatic t_saturate();
        sel = 1'b0; inv = 1'b0;
        to_neg(); code = 2'd1; mlo = 1'b1; mhi = 1'b1;
        for (int e = 1; e <= 20; e++) begin
            to_neg(); settle();
            chk("R7 held high, no wrap", qual, (e >= 2));
        end
        to_neg(); mhi = 1'b0; settle();
        chk("R8 drop on one match flag", qual, 1'b0);
        to_neg(); mlo = 1'b0; settle();
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_internal();
        t_ext();
        t_inv_ignored();
        t_zero_delay();
        t_window(2'd1, 2);
        t_window(2'd2, 4);
        t_window(2'd3, 8);
        t_short(2'd2, 4);
        t_short(2'd3, 8);
        t_saturate();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule